// File: doc/BRIEF.md
# Dual Packet-Buffer Word Access Port

This block lets a host processor on a 16-bit bus move data into and out of two byte-organized packet buffers: an isochronous buffer and an acknowledged buffer. The processor first loads a byte count into a transfer counter. It then writes a command code that picks one buffer and a direction. After that it streams any number of 16-bit words through one data register. The buffers themselves are modelled inside the block as word-wide pairs of byte banks.

An internal byte pointer starts at zero on each valid command and moves forward by two after every accepted word. On the access that brings the pointer to or past the byte count, the block signals end of transfer. That event sets a sticky interrupt bit and marks the selected buffer as done in a buffer status register. Once the count is reached, further data accesses do nothing until a new command is written. An odd byte count leaves a final word that carries only one valid byte. The two buffers place the even-address byte in opposite halves of the data word.

Register offsets on `cpu_addr`: 0 command (read returns the last accepted code), 1 data port, 2 transfer counter, 3 interrupt status, 4 buffer status. Offsets 5 to 7 read as zero.

Top module: `dual_buf_port`

## Requirements
- R1: A write to offset 0 with 0x40 selects an isochronous read, 0xC0 an isochronous write, 0x41 an acknowledged read and 0xC1 an acknowledged write. Any other code is ignored and leaves the transfer in progress, its pointer and the command readback unchanged.
- R2: After one command, any number of data-word accesses may follow up to the byte count without reissuing the command.
- R3: Each accepted data-word access moves the byte pointer forward by exactly two, so consecutive accesses reach consecutive word locations.
- R4: For the isochronous buffer, data bits 15:8 carry the byte at the even address and bits 7:0 carry the byte at the odd address.
- R5: For the acknowledged buffer, data bits 7:0 carry the even-address byte and bits 15:8 carry the odd-address byte.
- R6: The access that brings the pointer to or past the count (offset 2, bits 8:0 for the default depth) sets interrupt status bit 2 (offset 3). It also sets buffer status bit 0 for the isochronous buffer or bit 1 for the acknowledged buffer (offset 4).
- R7: When one byte remains, a data write stores only the even-address byte and ignores the other lane. A data read returns zero in the odd-address lane.
- R8: Data accesses made after the count is reached, or with a count of zero, are ignored. Reads return 0x0000, writes change no byte, the pointer does not move and no new event is raised.
- R9: A valid command resets the pointer to zero and clears the status bit of the buffer it selects.
- R10: Interrupt status bit 2 stays set until a write to offset 3 with bit 2 set. A write with bit 2 clear leaves it unchanged.
- R11: After the synchronous reset, the data output and every register read back as 0x0000.
- R12: A data write under a read command and a data read under a write command are ignored. The read returns 0x0000 and the pointer stays.
- R13: `cpu_rdata` takes the result of a read two rising edges after the edge that samples `cpu_rd`, and holds it until the next read result arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Read strobe, one access per cycle |
| cpu_wr | input | 1 | Write strobe, one access per cycle |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Registered read data |

## Verification
Words are written with an even count and read back with an odd count. This way the lone final byte shows up in a different lane for each buffer, which tells a correct lane mapping from a swapped one that would otherwise round-trip unseen. A partial write followed by a full-length read shows that only the valid lane of the final word was stored. Streams are interrupted by foreign codes, wrong-direction accesses and restarts, which separates a pointer that ignores these from one that moves or rewinds. A full-depth stream of 128 words checks pointer width and the end-of-transfer timing at the buffer's last word.

// File: rtl/bufport_pkg.sv
`timescale 1ns/1ps
package bufport_pkg;
  localparam logic [7:0] CMD_ISO_RD = 8'h40;
  localparam logic [7:0] CMD_ISO_WR = 8'hC0;
  localparam logic [7:0] CMD_ACK_RD = 8'h41;
  localparam logic [7:0] CMD_ACK_WR = 8'hC1;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] RA_CMD   = 3'd0;
  localparam logic [ADDR_W-1:0] RA_DATA  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_COUNT = 3'd2;
  localparam logic [ADDR_W-1:0] RA_IRQ   = 3'd3;
  localparam logic [ADDR_W-1:0] RA_BSTAT = 3'd4;
  localparam int IRQ_EOT_BIT = 2;

  typedef enum logic {BUF_ISO = 1'b0, BUF_ACK = 1'b1} buf_sel_e;

  typedef struct packed {
    logic [7:0] even;
    logic [7:0] odd;
  } byte_pair_t;

  // bus word -> even/odd bytes, lane order depends on buffer
  function automatic byte_pair_t unpack_word(input buf_sel_e b, input logic [15:0] w);
    byte_pair_t p;
    if (b == BUF_ISO) begin
      p.even = w[15:8];
      p.odd  = w[7:0];
    end else begin
      p.even = w[7:0];
      p.odd  = w[15:8];
    end
    return p;
  endfunction

  function automatic logic [15:0] pack_word(input buf_sel_e b, input byte_pair_t p);
    return (b == BUF_ISO) ? {p.even, p.odd} : {p.odd, p.even};
  endfunction
endpackage

// File: rtl/dbp_word_ram.sv
`timescale 1ns/1ps
module dbp_word_ram #(
  parameter int WORDS = 128,
  localparam int WAW = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           rd_en,
  input  logic           we_even,
  input  logic           we_odd,
  input  logic [WAW-1:0] addr,
  input  logic [7:0]     wd_even,
  input  logic [7:0]     wd_odd,
  output logic [7:0]     rd_even,
  output logic [7:0]     rd_odd
);
  logic [7:0] bank_e [WORDS];
  logic [7:0] bank_o [WORDS];

  // two byte-wide banks with per-byte write enable and registered read
  always_ff @(posedge clk) begin
    if (we_even) bank_e[addr] <= wd_even;
    if (rd_en)   rd_even      <= bank_e[addr];
  end

  always_ff @(posedge clk) begin
    if (we_odd) bank_o[addr] <= wd_odd;
    if (rd_en)  rd_odd       <= bank_o[addr];
  end
endmodule

// File: rtl/dbp_xfer_ctrl.sv
`timescale 1ns/1ps
module dbp_xfer_ctrl
  import bufport_pkg::*;
#(
  parameter int PTR_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_code,
  input  logic             cnt_we,
  input  logic [PTR_W-1:0] cnt_in,
  input  logic             data_rd,
  input  logic             data_wr,
  output logic [7:0]       cmd_q,
  output logic [PTR_W-1:0] cnt_q,
  output logic [PTR_W-1:0] ptr_q,
  output buf_sel_e         buf_q,
  output logic             cmd_load,
  output logic             active,
  output logic             rd_go,
  output logic             wr_go,
  output logic             tail,
  output logic             eot
);
  logic           armed_q;
  logic           dir_wr_q;
  logic           code_ok;
  logic [PTR_W:0] ptr_plus2;

  always_comb begin
    code_ok   = (cmd_code == CMD_ISO_RD) || (cmd_code == CMD_ISO_WR) ||
                (cmd_code == CMD_ACK_RD) || (cmd_code == CMD_ACK_WR);
    cmd_load  = cmd_we && code_ok;
    active    = armed_q && (ptr_q < cnt_q);
    rd_go     = data_rd && active && !dir_wr_q;
    wr_go     = data_wr && active && dir_wr_q;
    ptr_plus2 = {1'b0, ptr_q} + (PTR_W+1)'(2);
    tail      = ({1'b0, ptr_q} + (PTR_W+1)'(1)) == {1'b0, cnt_q};
    eot       = (rd_go || wr_go) && (ptr_plus2 >= {1'b0, cnt_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      ptr_q    <= '0;
      buf_q    <= BUF_ISO;
      armed_q  <= 1'b0;
      dir_wr_q <= 1'b0;
    end else if (cmd_load) begin
      cmd_q    <= cmd_code;
      ptr_q    <= '0;
      buf_q    <= buf_sel_e'(cmd_code[0]);
      dir_wr_q <= cmd_code[7];
      armed_q  <= 1'b1;
    end else if (rd_go || wr_go) begin
      ptr_q    <= ptr_plus2[PTR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_in;
  end
endmodule

// File: rtl/dual_buf_port.sv
`timescale 1ns/1ps
module dual_buf_port
  import bufport_pkg::*;
#(
  parameter int BUF_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [15:0]       cpu_wdata,
  output logic [15:0]       cpu_rdata
);
  localparam int WORDS = BUF_BYTES / 2;
  localparam int WAW   = $clog2(WORDS);
  localparam int PTR_W = $clog2(BUF_BYTES) + 1;

  logic             cmd_we, cnt_we, data_rd, data_wr, irq_clr;
  logic [7:0]       cmd_q;
  logic [PTR_W-1:0] cnt_q, ptr_w;
  buf_sel_e         buf_w;
  logic             cmd_load, active, rd_go, wr_go, tail, eot;
  byte_pair_t       wpair;
  logic [WAW-1:0]   word_addr;
  logic [1:0][7:0]  ram_even, ram_odd;

  logic             irq_q;
  logic [1:0]       bdone_q;

  logic             s1_valid, s1_is_data, s1_hit, s1_tail;
  buf_sel_e         s1_buf;
  logic [15:0]      s1_reg, reg_mux;
  byte_pair_t       rpair;

  always_comb begin
    cmd_we    = cpu_wr && (cpu_addr == RA_CMD);
    cnt_we    = cpu_wr && (cpu_addr == RA_COUNT);
    data_wr   = cpu_wr && (cpu_addr == RA_DATA);
    data_rd   = cpu_rd && (cpu_addr == RA_DATA);
    irq_clr   = cpu_wr && (cpu_addr == RA_IRQ) && cpu_wdata[IRQ_EOT_BIT];
    wpair     = unpack_word(buf_w, cpu_wdata);
    word_addr = ptr_w[PTR_W-2:1];
  end

  dbp_xfer_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmd_we   (cmd_we),
    .cmd_code (cpu_wdata[7:0]),
    .cnt_we   (cnt_we),
    .cnt_in   (cpu_wdata[PTR_W-1:0]),
    .data_rd  (data_rd),
    .data_wr  (data_wr),
    .cmd_q    (cmd_q),
    .cnt_q    (cnt_q),
    .ptr_q    (ptr_w),
    .buf_q    (buf_w),
    .cmd_load (cmd_load),
    .active   (active),
    .rd_go    (rd_go),
    .wr_go    (wr_go),
    .tail     (tail),
    .eot      (eot)
  );

  // one RAM per buffer; index 0 isochronous, index 1 acknowledged
  for (genvar g = 0; g < 2; g++) begin : g_buf
    logic sel;
    assign sel = (buf_w == buf_sel_e'(g));
    dbp_word_ram #(.WORDS(WORDS)) u_ram (
      .clk     (clk),
      .rd_en   (rd_go && sel),
      .we_even (wr_go && sel),
      .we_odd  (wr_go && sel && !tail),
      .addr    (word_addr),
      .wd_even (wpair.even),
      .wd_odd  (wpair.odd),
      .rd_even (ram_even[g]),
      .rd_odd  (ram_odd[g])
    );
  end

  // status: set has priority over the clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      bdone_q <= '0;
    end else begin
      if (eot)          irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (cmd_load)     bdone_q[cpu_wdata[0]] <= 1'b0;
      if (eot)          bdone_q[buf_w] <= 1'b1;
    end
  end

  always_comb begin
    case (cpu_addr)
      RA_CMD:   reg_mux = {8'h00, cmd_q};
      RA_COUNT: reg_mux = 16'(cnt_q);
      RA_IRQ:   reg_mux = 16'(irq_q) << IRQ_EOT_BIT;
      RA_BSTAT: reg_mux = {14'h0, bdone_q};
      default:  reg_mux = 16'h0000;
    endcase
  end

  // read stage 1: capture request and register value, RAM read in flight
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_is_data <= 1'b0;
      s1_hit     <= 1'b0;
      s1_tail    <= 1'b0;
      s1_buf     <= BUF_ISO;
      s1_reg     <= '0;
    end else begin
      s1_valid   <= cpu_rd;
      s1_is_data <= data_rd;
      s1_hit     <= rd_go;
      s1_tail    <= tail;
      s1_buf     <= buf_w;
      s1_reg     <= reg_mux;
    end
  end

  always_comb begin
    rpair.even = ram_even[s1_buf];
    rpair.odd  = s1_tail ? 8'h00 : ram_odd[s1_buf];
  end

  // read stage 2: registered output, held between reads
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
    end else if (s1_valid) begin
      if (s1_is_data) cpu_rdata <= s1_hit ? pack_word(s1_buf, rpair) : 16'h0000;
      else            cpu_rdata <= s1_reg;
    end
  end
endmodule

// File: rtl/dbp_checker.sv
`timescale 1ns/1ps
module dbp_checker #(
  parameter int PTR_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_load,
  input logic             active,
  input logic             eot,
  input logic [PTR_W-1:0] ptr_w,
  input logic             irq_q,
  input logic             irq_clr,
  input logic [1:0]       bdone_q,
  input logic             cpu_rd,
  input logic [15:0]      cpu_rdata
);
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
    !cmd_load |=> (ptr_w == $past(ptr_w)) || (ptr_w == $past(ptr_w) + PTR_W'(2)));

  p_cmd_rewind_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_load |=> (ptr_w == '0));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!active && !cmd_load) |=> $stable(ptr_w));

  p_eot_irq_r6: assert property (@(posedge clk) disable iff (rst)
    eot |=> irq_q);

  p_eot_bstat_r6: assert property (@(posedge clk) disable iff (rst)
    eot |=> (bdone_q != 2'b00));

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !irq_clr) |=> irq_q);

  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !$past(cpu_rd, 2) |-> $stable(cpu_rdata));
endmodule

bind dual_buf_port dbp_checker #(.PTR_W(PTR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cmd_load  (cmd_load),
  .active    (active),
  .eot       (eot),
  .ptr_w     (ptr_w),
  .irq_q     (irq_q),
  .irq_clr   (irq_clr),
  .bdone_q   (bdone_q),
  .cpu_rd    (cpu_rd),
  .cpu_rdata (cpu_rdata)
);

// File: tb/dual_buf_port_tb.sv
`timescale 1ns/1ps
module dual_buf_port_tb_top;
  localparam int BYTES = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [2:0]  cpu_addr = 3'd0;
  logic [15:0] cpu_wdata = 16'h0;
  logic [15:0] cpu_rdata;

  always #5 clk = ~clk;

  dual_buf_port #(.BUF_BYTES(BYTES)) dut_i (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R11";

  // behavioural reference model
  logic [7:0]  m_mem [2][BYTES];
  int          m_ptr = 0, m_cnt = 0, m_buf = 0;
  bit          m_armed = 0, m_dir_wr = 0, m_irq = 0;
  bit [1:0]    m_done = 0;
  logic [7:0]  m_cmd = 8'h00;
  logic [15:0] exp_out = 16'h0;
  bit          s1_v = 0;
  logic [15:0] s1_val = 16'h0;

  function automatic logic [15:0] lanes(int b, logic [7:0] ev, logic [7:0] od);
    return (b == 0) ? {ev, od} : {od, ev};
  endfunction

  task automatic model_op(bit rd, bit wr, logic [2:0] a, logic [15:0] d);
    logic [7:0] ev, od;
    s1_val = 16'h0;
    if (rd) begin
      case (a)
        3'd0: s1_val = {8'h00, m_cmd};
        3'd1: if (m_armed && !m_dir_wr && m_ptr < m_cnt) begin
                ev = m_mem[m_buf][m_ptr];
                od = (m_ptr + 1 < m_cnt) ? m_mem[m_buf][m_ptr+1] : 8'h00;
                s1_val = lanes(m_buf, ev, od);
                m_ptr += 2;
                if (m_ptr >= m_cnt) begin m_irq = 1; m_done[m_buf] = 1; end
              end
        3'd2: s1_val = 16'(m_cnt);
        3'd3: s1_val = m_irq ? 16'h0004 : 16'h0000;
        3'd4: s1_val = {14'h0, m_done};
        default: s1_val = 16'h0;
      endcase
    end
    if (wr) begin
      case (a)
        3'd0: if (d[7:0] == 8'h40 || d[7:0] == 8'hC0 || d[7:0] == 8'h41 || d[7:0] == 8'hC1) begin
                m_cmd = d[7:0]; m_buf = d[0]; m_dir_wr = d[7];
                m_armed = 1; m_ptr = 0; m_done[d[0]] = 0;
              end
        3'd1: if (m_armed && m_dir_wr && m_ptr < m_cnt) begin
                if (m_buf == 0) begin ev = d[15:8]; od = d[7:0]; end
                else            begin ev = d[7:0];  od = d[15:8]; end
                m_mem[m_buf][m_ptr] = ev;
                if (m_ptr + 1 < m_cnt) m_mem[m_buf][m_ptr+1] = od;
                m_ptr += 2;
                if (m_ptr >= m_cnt) begin m_irq = 1; m_done[m_buf] = 1; end
              end
        3'd2: m_cnt = int'(d[8:0]);
        3'd3: if (d[2]) m_irq = 0;
        default: ;
      endcase
    end
  endtask

  // one bus cycle: compare output, drive inputs, advance the model
  task automatic step(bit rd, bit wr, logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    checks++;
    if (cpu_rdata !== exp_out) begin
      errors++;
      $display("FAIL %s: cpu_rdata=%h expected %h at %0t", cur_req, cpu_rdata, exp_out, $time);
    end
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    if (s1_v) exp_out = s1_val;
    s1_v = rd;
    model_op(rd, wr, a, d);
  endtask

  task automatic wr_reg(logic [2:0] a, logic [15:0] d); step(0, 1, a, d); endtask
  task automatic rd_reg(logic [2:0] a);                 step(1, 0, a, 16'h0); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) step(0, 0, 3'd0, 16'h0); endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(2_000_000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11: reset state of every readable register
    cur_req = "R11";
    for (int a = 0; a < 8; a++) rd_reg(3'(a));
    idle(3);

    // R1 R2 R3 R6: isochronous write of 4 words, event and status
    cur_req = "R6";
    wr_reg(3'd2, 16'd8);
    wr_reg(3'd0, 16'h00C0);
    wr_reg(3'd1, 16'hA1B2); wr_reg(3'd1, 16'hC3D4);
    wr_reg(3'd1, 16'hE5F6); wr_reg(3'd1, 16'h0718);
    rd_reg(3'd3); rd_reg(3'd4); rd_reg(3'd0); idle(3);

    // R10: sticky interrupt, write-one-to-clear
    cur_req = "R10";
    wr_reg(3'd3, 16'h0000); rd_reg(3'd3); idle(2);
    wr_reg(3'd3, 16'h0004); rd_reg(3'd3); idle(3);

    // R4: read back isochronous words, lane order
    cur_req = "R4";
    wr_reg(3'd0, 16'h0040);
    for (int i = 0; i < 4; i++) rd_reg(3'd1);
    idle(3);

    // R8: reads after end of transfer return zero, writes do nothing
    cur_req = "R8";
    rd_reg(3'd1); rd_reg(3'd1); rd_reg(3'd4); idle(3);

    // R7 R4: odd count read exposes the even byte in bits 15:8
    cur_req = "R7";
    wr_reg(3'd2, 16'd7); wr_reg(3'd0, 16'h0040);
    for (int i = 0; i < 4; i++) rd_reg(3'd1);
    idle(2);
    // R7: odd count write keeps the odd byte of the last word
    wr_reg(3'd2, 16'd5); wr_reg(3'd0, 16'h00C0);
    wr_reg(3'd1, 16'h1111); wr_reg(3'd1, 16'h2222); wr_reg(3'd1, 16'h3355);
    wr_reg(3'd2, 16'd6); wr_reg(3'd0, 16'h0040);
    for (int i = 0; i < 3; i++) rd_reg(3'd1);
    idle(3);

    // R5: acknowledged buffer lane swap, seen through an odd count read
    cur_req = "R5";
    wr_reg(3'd2, 16'd6); wr_reg(3'd0, 16'h00C1);
    wr_reg(3'd1, 16'hAB01); wr_reg(3'd1, 16'hCD02); wr_reg(3'd1, 16'hEF03);
    rd_reg(3'd4);
    wr_reg(3'd2, 16'd5); wr_reg(3'd0, 16'h0041);
    for (int i = 0; i < 3; i++) rd_reg(3'd1);
    idle(3);

    // R12: wrong-direction accesses are ignored
    cur_req = "R12";
    wr_reg(3'd0, 16'h0041);
    wr_reg(3'd1, 16'hFFFF);
    rd_reg(3'd1);
    wr_reg(3'd0, 16'h00C1);
    rd_reg(3'd1);
    wr_reg(3'd0, 16'h0041);
    rd_reg(3'd1); rd_reg(3'd1); idle(3);

    // R1: foreign command code leaves the transfer running
    cur_req = "R1";
    wr_reg(3'd2, 16'd6); wr_reg(3'd0, 16'h0041);
    rd_reg(3'd1);
    wr_reg(3'd0, 16'h0042);
    rd_reg(3'd1); rd_reg(3'd0); rd_reg(3'd1);
    idle(3);

    // R9: new command rewinds the pointer and clears that buffer's status
    cur_req = "R9";
    rd_reg(3'd4);
    wr_reg(3'd0, 16'h0041);
    rd_reg(3'd4); rd_reg(3'd1);
    wr_reg(3'd0, 16'h0041);
    rd_reg(3'd1); idle(3);

    // R8: a count of zero gives no data and no event
    cur_req = "R8";
    wr_reg(3'd3, 16'h0004);
    wr_reg(3'd2, 16'd0); wr_reg(3'd0, 16'h0040);
    rd_reg(3'd1); rd_reg(3'd3); rd_reg(3'd2); idle(3);

    // R2 R3: full-depth stream with no repeated command
    cur_req = "R3";
    wr_reg(3'd2, 16'(BYTES)); wr_reg(3'd0, 16'h00C0);
    for (int i = 0; i < BYTES/2; i++) wr_reg(3'd1, 16'(i * 16'h0203) ^ 16'h5A00);
    cur_req = "R2";
    rd_reg(3'd3);
    wr_reg(3'd3, 16'h0004);
    wr_reg(3'd0, 16'h0040);
    for (int i = 0; i < BYTES/2; i++) rd_reg(3'd1);
    rd_reg(3'd3); rd_reg(3'd4);

    // R13: output holds across idle cycles after a read
    cur_req = "R13";
    rd_reg(3'd2); idle(6);
    rd_reg(3'd0); step(0, 1, 3'd2, 16'd12); idle(4);

    summary();
    $finish;
  end
endmodule